// File: doc/BRIEF.md
# External Interrupt Source Aggregator

This block gathers event signals from on-chip peripherals and turns them into seven interrupt request lines, numbered 0 to 6, for an 8051-style processor core. Every source first crosses a synchronizer. An edge detector then picks out the edge each line needs. Some lines carry a single source. Lines 2, 4 and 6 carry several sub-sources. Each sub-source has its own enable bit and its own sticky flag, and the enabled sub-flags are ORed into the shared line.

Lines 0 to 5 each keep a main flag. The flag is set by the line's edge and cleared when the core acknowledges that vector. Line 6 has no main flag: its request is a level that stays high while any enabled sub-flag on it is set. Software clears sub-flags by writing a byte with a zero in the bit to clear. Ones written to the register do nothing. This means a read-modify-write of the whole byte can never wipe out a flag that was set after the read.

Top module: `ext_irq_aggregator`

## Requirements
- R1: After reset, all enables, polarity bits, main flags and sub-flags are 0. `irq_o` is 0 and every register reads 0.
- R2: Lines 0 and 1 set their main flag on a falling edge of `src_i[0]` and `src_i[1]`. Line 5 sets its main flag on a falling edge of `src_i[7]`. Rising edges on these sources set nothing.
- R3: Line 3 takes `src_i[5]`. Line 2 takes the OR of its enabled sub-flags. Control register bit 1 selects the edge for line 3 and bit 0 selects it for line 2: 0 means falling edge, 1 means rising edge.
- R4: A rising edge of `src_i[6]` sets sub-flag bit 3 and a falling edge sets sub-flag bit 4. Line 4 sets its main flag on a rising edge of the OR of these two flags, each ANDed with its enable.
- R5: Rising edges of `src_i[2]`, `src_i[3]` and `src_i[4]` set sub-flag bits 0, 1 and 2, which feed line 2. While the line 2 aggregate is already high, a further sub-source event makes no new line 2 edge.
- R6: A main flag on lines 0 to 5 clears when `ack_i` has that bit high at a clock edge. If the flag's set event lands in the same cycle, the set wins.
- R7: Writing to the sub-flag register (address 3) clears each flag whose written bit is 0. Flags whose written bit is 1 keep their value.
- R8: If a sub-source event and a clearing write hit the same sub-flag in the same cycle, the flag ends up set.
- R9: For k in 0..5, `irq_o[k]` equals main flag k ANDed with line enable bit k. A flag that is set but not enabled still reads back as 1 at address 1.
- R10: `irq_o[6]` is line enable bit 6 ANDed with the OR over sub-flag bits 5..7 (from rising edges of `src_i[8]`, `src_i[9]`, `src_i[10]`), each ANDed with its sub-enable. `ack_i[6]` has no effect. Address 1 bit 6 reads this aggregate.
- R11: A source edge on a direct line shows up in `irq_o` after the third rising clock edge that follows the input change, and not before (two synchronizer stages plus the flag register).
- R12: The register map is: address 0 holds the line enables in bits 6:0. Address 1 holds the line flags and is read-only. Address 2 holds the sub-enables. Address 3 holds the sub-flags. Address 4 holds the polarity bits 1:0. All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 11 | Peripheral event inputs, asynchronous |
| ack_i | input | 7 | Vector acknowledge strobes from the core, one per line |
| sfr_addr_i | input | 3 | Register address |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_o | output | 7 | Interrupt request lines to the core |

## Verification
The bench builds the block with the default depth of two synchronizer stages. At that depth the exact latency of three clock edges can be checked at the ports, and a clearing write or an acknowledge can be placed on the very edge where a set pulse arrives. That timing makes both set-wins races reachable from outside. It also covers the cases where a shared line does not retrigger while its aggregate stays high, and where line 2 raises a request only when software clears its last sub-flag in falling-edge mode.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_LINES = 7;
  localparam int NUM_MAIN  = 6;
  localparam int NUM_SRC   = 11;
  localparam int NUM_SUB   = 8;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;

  // source input positions
  localparam int SRC_L0    = 0;
  localparam int SRC_L1    = 1;
  localparam int SRC_COL0  = 2;
  localparam int SRC_COL1  = 3;
  localparam int SRC_SPI   = 4;
  localparam int SRC_L3    = 5;
  localparam int SRC_LOCK  = 6;
  localparam int SRC_L5    = 7;
  localparam int SRC_XFER  = 8;
  localparam int SRC_TICK  = 9;
  localparam int SRC_WDOG  = 10;

  typedef enum logic [ADDR_W-1:0] {
    REG_LINE_EN   = 3'd0,
    REG_LINE_FLAG = 3'd1,
    REG_SUB_EN    = 3'd2,
    REG_SUB_FLAG  = 3'd3,
    REG_CTRL      = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/eia_edge.sv
module eia_edge #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign level_o = d_i;
    end else begin : g_sync
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign level_o = stage_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_o;
  end

  assign rise_o = level_o & ~prev_q;
  assign fall_o = ~level_o & prev_q;

  // R11: a detected edge lasts one cycle
  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/eia_sub_flags.sv
module eia_sub_flags #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q, clr_mask;

  assign clr_mask = clr_wr_i ? ~wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_mask) | set_i;
  end

  assign flag_o = flag_q;

  // R7: written ones never clear a set flag
  a_r7_ones_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((flag_q & $past(flag_q & wdata_i)) == $past(flag_q & wdata_i)));
  // R8: set beats a same-cycle clear
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/eia_main_flags.sv
module eia_main_flags #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~ack_i) | set_i;
  end

  assign flag_o = flag_q;

  // R6: acknowledge clears unless a set arrives together
  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack_i & ~set_i)) |=> ((flag_q & $past(ack_i & ~set_i)) == '0));
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/ext_irq_aggregator.sv
module ext_irq_aggregator
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic [NUM_LINES-1:0] ack_i,
  input  logic [ADDR_W-1:0]    sfr_addr_i,
  input  logic                 sfr_wr_i,
  input  logic [DATA_W-1:0]    sfr_wdata_i,
  output logic [DATA_W-1:0]    sfr_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_LINES-1:0] line_en_q;
  logic [NUM_SUB-1:0]   sub_en_q;
  logic [1:0]           pol_q;
  reg_addr_e            addr;

  logic [NUM_SRC-1:0]  src_lvl, src_rise, src_fall;
  logic [NUM_SUB-1:0]  sub_set, sub_flag, sub_act;
  logic                sub_clr_wr;
  logic                agg2, agg4, agg6;
  logic [1:0]          agg_lvl, agg_rise, agg_fall;
  logic [NUM_MAIN-1:0] main_set, main_flag;
  logic                unused_edges;

  assign addr = reg_addr_e'(sfr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_en_q <= '0;
      sub_en_q  <= '0;
      pol_q     <= '0;
    end else if (sfr_wr_i) begin
      case (addr)
        REG_LINE_EN: line_en_q <= sfr_wdata_i[NUM_LINES-1:0];
        REG_SUB_EN:  sub_en_q  <= sfr_wdata_i;
        REG_CTRL:    pol_q     <= sfr_wdata_i[1:0];
        default: ;
      endcase
    end
  end

  eia_edge #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_src_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_i),
    .level_o(src_lvl), .rise_o(src_rise), .fall_o(src_fall)
  );

  assign sub_set = {src_rise[SRC_WDOG], src_rise[SRC_TICK], src_rise[SRC_XFER],
                    src_fall[SRC_LOCK], src_rise[SRC_LOCK],
                    src_rise[SRC_SPI], src_rise[SRC_COL1], src_rise[SRC_COL0]};
  assign sub_clr_wr = sfr_wr_i && (addr == REG_SUB_FLAG);

  eia_sub_flags #(.W(NUM_SUB)) u_sub_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(sub_set),
    .clr_wr_i(sub_clr_wr), .wdata_i(sfr_wdata_i), .flag_o(sub_flag)
  );

  assign sub_act = sub_flag & sub_en_q;
  assign agg2 = |sub_act[2:0];
  assign agg4 = |sub_act[4:3];
  assign agg6 = |sub_act[7:5];

  eia_edge #(.W(2), .STAGES(0)) u_agg_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({agg4, agg2}),
    .level_o(agg_lvl), .rise_o(agg_rise), .fall_o(agg_fall)
  );

  always_comb begin
    main_set[0] = src_fall[SRC_L0];
    main_set[1] = src_fall[SRC_L1];
    main_set[2] = pol_q[0] ? agg_rise[0] : agg_fall[0];
    main_set[3] = pol_q[1] ? src_rise[SRC_L3] : src_fall[SRC_L3];
    main_set[4] = agg_rise[1];
    main_set[5] = src_fall[SRC_L5];   // inverted source, rising-edge line
  end

  eia_main_flags #(.W(NUM_MAIN)) u_main_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(main_set),
    .ack_i(ack_i[NUM_MAIN-1:0]), .flag_o(main_flag)
  );

  assign irq_o = {line_en_q[6] & agg6, main_flag & line_en_q[NUM_MAIN-1:0]};

  always_comb begin
    case (addr)
      REG_LINE_EN:   sfr_rdata_o = {1'b0, line_en_q};
      REG_LINE_FLAG: sfr_rdata_o = {1'b0, agg6, main_flag};
      REG_SUB_EN:    sfr_rdata_o = sub_en_q;
      REG_SUB_FLAG:  sfr_rdata_o = sub_flag;
      REG_CTRL:      sfr_rdata_o = {6'b0, pol_q};
      default:       sfr_rdata_o = '0;
    endcase
  end

  assign unused_edges = ^{src_lvl, agg_lvl, ack_i[6],
                          src_rise[SRC_L0], src_rise[SRC_L1], src_rise[SRC_L5],
                          src_fall[SRC_COL0], src_fall[SRC_COL1], src_fall[SRC_SPI],
                          src_fall[SRC_XFER], src_fall[SRC_TICK], src_fall[SRC_WDOG]};

  // R9: no request without its line enable
  a_r9_gated_by_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~line_en_q) == '0);
  // R10: line 6 only drops through a register write
  a_r10_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[6] && !sfr_wr_i) |=> irq_o[6]);
  // R1: request lines quiet right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (irq_o == '0));
endmodule

// File: tb/tb_ext_irq_aggregator.sv
module tb_ext_irq_aggregator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_ni = 0;
  logic [10:0] src = '0;
  logic [6:0]  ack = '0;
  logic [2:0]  addr = '0;
  logic        wr = 0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [6:0]  irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  string       req_q[$];
  logic [16:0] item_q[$];   // {sel, mask, exp}; sel 1 = read data

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_aggregator #(.SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .ack_i(ack),
    .sfr_addr_i(addr), .sfr_wr_i(wr), .sfr_wdata_i(wdata),
    .sfr_rdata_o(rdata), .irq_o(irq)
  );

  // monitor: pop expected items and compare away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (item_q.size() > 0) begin
        automatic logic [16:0] it = item_q.pop_front();
        automatic string r = req_q.pop_front();
        automatic logic [7:0] act = it[16] ? rdata : {1'b0, irq};
        n_tests++;
        if ((act & it[15:8]) !== it[7:0]) begin
          n_fail++;
          $display("FAIL %s: act=%02h exp=%02h mask=%02h", r, act & it[15:8], it[7:0], it[15:8]);
        end
      end
    end
  end

  task automatic chk_irq(string r, logic [7:0] mask, logic [7:0] exp);
    req_q.push_back(r);
    item_q.push_back({1'b0, mask, exp});
    wait (item_q.size() == 0);
  endtask

  task automatic chk_rd(string r, logic [2:0] a, logic [7:0] mask, logic [7:0] exp);
    addr = a;
    req_q.push_back(r);
    item_q.push_back({1'b1, mask, exp});
    wait (item_q.size() == 0);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic pulse_ack(int k);
    ack[k] = 1;
    @(negedge clk);
    ack[k] = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc(1);
    // R1 reset state, R12 map
    chk_irq("R1", 8'h7F, 8'h00);
    for (int a = 0; a < 8; a++) chk_rd("R1", 3'(a), 8'hFF, 8'h00);

    wr_reg(3'd0, 8'h7F);
    chk_rd("R12", 3'd0, 8'hFF, 8'h7F);
    wr_reg(3'd5, 8'hFF);
    chk_rd("R12", 3'd5, 8'hFF, 8'h00);

    // R2 rising on line 0 does nothing; R11 falling latency
    src[0] = 1; cyc(5);
    chk_irq("R2", 8'h01, 8'h00);
    src[0] = 0; cyc(2);
    chk_irq("R11", 8'h01, 8'h00);
    cyc(1);
    chk_irq("R11", 8'h01, 8'h01);
    pulse_ack(0);
    chk_irq("R6", 8'h01, 8'h00);

    // R6 set wins over same-cycle acknowledge
    src[0] = 1; cyc(5);
    src[0] = 0; cyc(2);
    pulse_ack(0);
    chk_irq("R6", 8'h01, 8'h01);
    pulse_ack(0);

    // R9 enable gating on line 1
    src[1] = 1; cyc(5); src[1] = 0; cyc(5);
    chk_irq("R2", 8'h02, 8'h02);
    wr_reg(3'd0, 8'h7D);
    chk_irq("R9", 8'h02, 8'h00);
    chk_rd("R9", 3'd1, 8'h02, 8'h02);
    pulse_ack(1);
    wr_reg(3'd0, 8'h7F);

    // R2 line 5 inverted source
    src[7] = 1; cyc(5);
    chk_irq("R2", 8'h20, 8'h00);
    src[7] = 0; cyc(5);
    chk_irq("R2", 8'h20, 8'h20);
    pulse_ack(5);

    // R3 line 3 polarity
    src[5] = 1; cyc(5);
    chk_irq("R3", 8'h08, 8'h00);
    src[5] = 0; cyc(5);
    chk_irq("R3", 8'h08, 8'h08);
    pulse_ack(3);
    wr_reg(3'd4, 8'h02);
    src[5] = 1; cyc(5);
    chk_irq("R3", 8'h08, 8'h08);
    pulse_ack(3);

    // R5 line 2 shared, rising mode
    wr_reg(3'd2, 8'h07);
    wr_reg(3'd4, 8'h03);
    src[2] = 1; cyc(6);
    chk_rd("R5", 3'd3, 8'hFF, 8'h01);
    chk_irq("R5", 8'h04, 8'h04);
    pulse_ack(2);
    src[3] = 1; cyc(6);
    chk_irq("R5", 8'h04, 8'h00);
    chk_rd("R5", 3'd3, 8'hFF, 8'h03);
    // R7 zero clears, ones keep
    wr_reg(3'd3, 8'hFE);
    chk_rd("R7", 3'd3, 8'hFF, 8'h02);
    wr_reg(3'd3, 8'hFD);
    chk_rd("R7", 3'd3, 8'hFF, 8'h00);
    cyc(3);
    chk_irq("R3", 8'h04, 8'h00);
    // R3 falling mode on line 2
    wr_reg(3'd4, 8'h02);
    src[4] = 1; cyc(6);
    chk_irq("R3", 8'h04, 8'h00);
    wr_reg(3'd3, 8'hFB);
    cyc(3);
    chk_irq("R3", 8'h04, 8'h04);
    pulse_ack(2);
    src[2] = 0; src[3] = 0; src[4] = 0; cyc(4);

    // R4 lock signal both edges
    wr_reg(3'd2, 8'h1F);
    src[6] = 1; cyc(6);
    chk_rd("R4", 3'd3, 8'hFF, 8'h08);
    chk_irq("R4", 8'h10, 8'h10);
    pulse_ack(4);
    wr_reg(3'd3, 8'hF7);
    cyc(3);
    src[6] = 0; cyc(6);
    chk_rd("R4", 3'd3, 8'hFF, 8'h10);
    chk_irq("R4", 8'h10, 8'h10);
    pulse_ack(4);
    wr_reg(3'd3, 8'hEF);

    // R10 line 6 level request
    wr_reg(3'd2, 8'h7F);
    src[9] = 1; cyc(5);
    chk_irq("R10", 8'h40, 8'h40);
    chk_rd("R10", 3'd1, 8'h40, 8'h40);
    pulse_ack(6);
    cyc(2);
    chk_irq("R10", 8'h40, 8'h40);
    wr_reg(3'd3, 8'hBF);
    chk_irq("R10", 8'h40, 8'h00);
    src[10] = 1; cyc(5);
    chk_rd("R10", 3'd3, 8'h80, 8'h80);
    chk_irq("R10", 8'h40, 8'h00);

    // R8 set wins over same-cycle clearing write
    src[8] = 1; cyc(2);
    wr_reg(3'd3, 8'h00);
    chk_rd("R8", 3'd3, 8'hFF, 8'h20);
    chk_irq("R8", 8'h40, 8'h40);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule